// File: doc/BRIEF.md
# Dual-Lane Word SIMD Add/Accumulate Unit

This execute unit has its own bank of seventeen 32-bit media registers. It decodes 32-bit instruction words from the shared extension opcode space. A dual add writes two destinations at once. Each destination receives the sum or the difference of the same two source registers, and a 2-bit selector picks the operation for each lane. A dual accumulate does the same arithmetic but adds each lane result onto the old value of its destination. Two move forms copy a word between a media register and the general-purpose side. For the inbound move, the general-purpose value is presented on an input port. For the outbound move, the value appears on a registered write port together with the general-purpose register number.

Media register 0 always reads as zero and ignores writes. Register 16 can be reached only by the move forms. All arithmetic wraps modulo 2^32. Instruction words that this unit does not own have no effect. A combinational debug port reads any media register.

Top module: `dsimd_addacc`

## Requirements
- R1: Only words with bits [31:26] = 011100 and minor opcode bits [5:0] equal to 011000 (dual add), 011001 (dual accumulate), 101110 (media to general-purpose) or 101111 (general-purpose to media) have any effect. Every other word changes no media register and raises no general-purpose write.
- R2: Dual add reads fields XD=[21:18], XC=[17:14], XB=[13:10] and XA=[9:6], and writes XA = XB op1 XC and XD = XB op2 XC. Selector bit 25 set makes op1 a subtraction and bit 24 set makes op2 a subtraction, so 00 is add/add, 01 add/sub, 10 sub/add and 11 sub/sub. XB is always the minuend.
- R3: Dual accumulate uses the same fields and selector, and writes XA = oldXA + (XB op1 XC) and XD = oldXD + (XB op2 XC).
- R4: All sums and differences wrap modulo 2^32, with no saturation.
- R5: Media register 0 always reads zero, as a source and on the debug port. A write aimed at it is discarded.
- R6: Every source, including the old destination values for accumulation, is read before any write of the same instruction. When XA equals XD, that register takes the XD lane result.
- R7: The general-purpose-to-media move writes gpr_rdata, sampled in the cycle of the strobe, into the media register named by bits [10:6]. Value 16 reaches register 16. Values 17 to 31 write nothing.
- R8: The media-to-general-purpose move raises gpr_we for exactly one cycle, in the cycle after the strobe. In that cycle gpr_wdata holds the media register named by bits [10:6] (zero for 17 to 31) and gpr_wnum holds bits [20:16].
- R9: An instruction's media write is visible one clock after the cycle in which insn_valid is high. With insn_valid low, no register changes.
- R10: While rst_n is low at a rising clock edge, every media register and gpr_we, gpr_wdata and gpr_wnum are cleared to zero.
- R11: A dual add or dual accumulate word with bits [23:22] not equal to 00 is a no-op.
- R12: dbg_data shows media register dbg_sel for values 0 to 16, and zero for any larger value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| gpr_rdata | input | 32 | General-purpose source value for the inbound move |
| gpr_we | output | 1 | General-purpose write enable (outbound move) |
| gpr_wnum | output | 5 | General-purpose destination register number |
| gpr_wdata | output | 32 | General-purpose write value |
| dbg_sel | input | 5 | Debug read register select |
| dbg_data | output | 32 | Debug read value |

## Verification
Each media-register result is due one clock after its strobe. The bench raises insn_valid for one cycle from a falling edge. It then inspects all seventeen registers through the debug port after the following falling edge, once the strobe has dropped, so no later instruction can overlap. The outbound move's write port is due in that same cycle. It is checked there, and checked again one cycle later to confirm that gpr_we has returned low. Reset contents are read through the debug port before the first instruction.

// File: rtl/dsimd_pkg.sv
`timescale 1ns/1ps
// Shared constants and decoded-instruction type for the dual-lane SIMD unit.
// Assumes the fixed 32-bit instruction layout of the extension opcode space.
package dsimd_pkg;
    localparam int WORD_W = 32;
    localparam logic [5:0] MAJOR_OP = 6'b011100;
    localparam logic [5:0] MIN_DADD = 6'b011000;
    localparam logic [5:0] MIN_DACC = 6'b011001;
    localparam logic [5:0] MIN_M2G  = 6'b101110;
    localparam logic [5:0] MIN_G2M  = 6'b101111;

    typedef enum logic [2:0] {
        K_NOP, K_ADD, K_ACC, K_M2G, K_G2M
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       sub_a;   // lane written to XA subtracts
        logic       sub_d;   // lane written to XD subtracts
        logic [3:0] xa;
        logic [3:0] xb;
        logic [3:0] xc;
        logic [3:0] xd;
        logic [4:0] xm;      // move media index (0..16 valid)
        logic [4:0] gnum;    // general-purpose register number
    } dec_t;
endpackage

// File: rtl/dsimd_decode.sv
`timescale 1ns/1ps
// Instruction decoder: classifies a word and extracts its register fields.
// Assumes: words outside the owned opcodes decode as K_NOP.
module dsimd_decode
    import dsimd_pkg::*;
(
    input  logic [31:0] word_i,
    output dec_t        dec_o
);
    logic is_major;
    logic pad_ok;

    // Classify the word and slice out every field.
    always_comb begin
        is_major   = (word_i[31:26] == MAJOR_OP);
        pad_ok     = (word_i[23:22] == 2'b00);
        dec_o.kind = K_NOP;
        if (is_major) begin
            unique case (word_i[5:0])
                MIN_DADD: dec_o.kind = pad_ok ? K_ADD : K_NOP;
                MIN_DACC: dec_o.kind = pad_ok ? K_ACC : K_NOP;
                MIN_M2G:  dec_o.kind = K_M2G;
                MIN_G2M:  dec_o.kind = K_G2M;
                default:  dec_o.kind = K_NOP;
            endcase
        end
        dec_o.sub_a = word_i[25];
        dec_o.sub_d = word_i[24];
        dec_o.xd    = word_i[21:18];
        dec_o.xc    = word_i[17:14];
        dec_o.xb    = word_i[13:10];
        dec_o.xa    = word_i[9:6];
        dec_o.xm    = word_i[10:6];
        dec_o.gnum  = word_i[20:16];
    end
endmodule

// File: rtl/dsimd_lane.sv
`timescale 1ns/1ps
// One arithmetic lane: (acc ? old : 0) + (b +/- c), wrapping modulo 2^W.
// Assumes: operands are already read from the register bank.
module dsimd_lane #(
    parameter int W = 32
) (
    input  logic         sub_i,
    input  logic         acc_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] old_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] core;

    // Form the lane sum or difference, then optionally accumulate.
    always_comb begin
        core  = sub_i ? (b_i - c_i) : (b_i + c_i);
        res_o = (acc_i ? old_i : '0) + core;
    end
endmodule

// File: rtl/dsimd_regfile.sv
`timescale 1ns/1ps
// Media register bank with two write ports; entry 0 is constant zero.
// Assumes: port 1 has priority when both ports name the same entry.
module dsimd_regfile #(
    parameter int W    = 32,
    parameter int NREG = 17,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we0_i,
    input  logic [AW-1:0]            addr0_i,
    input  logic [W-1:0]             wd0_i,
    input  logic                     we1_i,
    input  logic [AW-1:0]            addr1_i,
    input  logic [W-1:0]             wd1_i,
    output logic [NREG-1:0][W-1:0]   regs_o
);
    assign regs_o[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_ent
        logic [W-1:0] q;
        // Hold one entry; port 1 overrides port 0.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we1_i && addr1_i == AW'(g))
                q <= wd1_i;
            else if (we0_i && addr0_i == AW'(g))
                q <= wd0_i;
        end
        assign regs_o[g] = q;
    end
endmodule

// File: rtl/dsimd_addacc.sv
`timescale 1ns/1ps
// Dual-lane word SIMD add/accumulate unit with its own media register bank
// and word moves to and from the general-purpose side.
// Assumes: one instruction per valid cycle; results land one clock later.
module dsimd_addacc
    import dsimd_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int NREG = 17,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_valid,
    input  logic [31:0]   insn_word,
    input  logic [W-1:0]  gpr_rdata,
    output logic          gpr_we,
    output logic [4:0]    gpr_wnum,
    output logic [W-1:0]  gpr_wdata,
    input  logic [AW-1:0] dbg_sel,
    output logic [W-1:0]  dbg_data
);
    dec_t                   dec;
    logic [NREG-1:0][W-1:0] xr_q;
    logic [1:0][W-1:0]      lane_res;
    logic                   arith;
    logic                   m_ok;
    logic                   we0, we1;
    logic [AW-1:0]          addr0, addr1;
    logic [W-1:0]           wd0;
    logic [W-1:0]           m_val;

    dsimd_decode u_dec (.word_i(insn_word), .dec_o(dec));

    // Lane 0 feeds XA, lane 1 feeds XD; both read the bank before writes.
    for (genvar l = 0; l < 2; l++) begin : g_lane
        dsimd_lane #(.W(W)) u_lane (
            .sub_i (l == 0 ? dec.sub_a : dec.sub_d),
            .acc_i (dec.kind == K_ACC),
            .b_i   (xr_q[dec.xb]),
            .c_i   (xr_q[dec.xc]),
            .old_i (l == 0 ? xr_q[dec.xa] : xr_q[dec.xd]),
            .res_o (lane_res[l])
        );
    end

    // Steer the lane results and inbound move onto the bank write ports.
    always_comb begin
        arith = insn_valid && (dec.kind == K_ADD || dec.kind == K_ACC);
        m_ok  = (dec.xm < 5'(NREG));
        m_val = m_ok ? xr_q[AW'(dec.xm)] : '0;
        we0   = arith || (insn_valid && dec.kind == K_G2M && m_ok);
        addr0 = (dec.kind == K_G2M) ? AW'(dec.xm) : AW'(dec.xa);
        wd0   = (dec.kind == K_G2M) ? gpr_rdata : lane_res[0];
        we1   = arith;
        addr1 = AW'(dec.xd);
    end

    dsimd_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we0_i   (we0),
        .addr0_i (addr0),
        .wd0_i   (wd0),
        .we1_i   (we1),
        .addr1_i (addr1),
        .wd1_i   (lane_res[1]),
        .regs_o  (xr_q)
    );

    // Register the outbound move onto the general-purpose write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpr_we    <= 1'b0;
            gpr_wnum  <= '0;
            gpr_wdata <= '0;
        end else begin
            gpr_we    <= insn_valid && dec.kind == K_M2G;
            gpr_wnum  <= dec.gnum;
            gpr_wdata <= m_val;
        end
    end

    // Debug read of any media register, zero beyond the bank.
    always_comb dbg_data = (dbg_sel < AW'(NREG)) ? xr_q[dbg_sel] : '0;
endmodule

// File: rtl/dsimd_addacc_chk.sv
`timescale 1ns/1ps
// Property checker for dsimd_addacc, attached by bind below.
// Assumes the default bank size of 17 words.
module dsimd_addacc_chk #(
    parameter int W    = 32,
    parameter int NREG = 17,
    localparam int AW  = $clog2(NREG)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   insn_valid,
    input logic [31:0]            insn_word,
    input logic                   gpr_we,
    input logic [AW-1:0]          dbg_sel,
    input logic [W-1:0]           dbg_data,
    input logic [NREG-1:0][W-1:0] xr_q
);
    logic       is_m2g, is_add00;
    logic [3:0] f_xd, f_xb, f_xc;

    // Decode just enough of the word to state the properties.
    always_comb begin
        is_m2g   = insn_valid && insn_word[31:26] == 6'b011100 && insn_word[5:0] == 6'b101110;
        is_add00 = insn_valid && insn_word[31:22] == 10'b0111000000 && insn_word[5:0] == 6'b011000;
        f_xd     = insn_word[21:18];
        f_xc     = insn_word[17:14];
        f_xb     = insn_word[13:10];
    end

    // R5
    xr0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_sel == '0 |-> dbg_data == '0);

    // R8
    m2g_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_m2g |=> gpr_we);

    // R8
    we_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> $past(is_m2g));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> $stable(xr_q));

    // R2
    add_xd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_add00 && f_xd != 4'd0) |=> xr_q[$past(f_xd)] == $past(xr_q[f_xb] + xr_q[f_xc]));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (xr_q == '0 && !gpr_we));
endmodule

bind dsimd_addacc dsimd_addacc_chk #(.W(W), .NREG(NREG)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .gpr_we     (gpr_we),
    .dbg_sel    (dbg_sel),
    .dbg_data   (dbg_data),
    .xr_q       (xr_q)
);

// File: tb/dsimd_addacc_tb_top.sv
`timescale 1ns/1ps
module dsimd_addacc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] gpr_rdata = '0;
    logic        gpr_we;
    logic [4:0]  gpr_wnum;
    logic [31:0] gpr_wdata;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [17];

    always #10 clk = ~clk;

    dsimd_addacc dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .gpr_rdata(gpr_rdata), .gpr_we(gpr_we), .gpr_wnum(gpr_wnum),
        .gpr_wdata(gpr_wdata), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare the whole bank (plus two out-of-range selects) with the model.
    task automatic sweep(string req);
        for (int i = 0; i < 19; i++) begin
            dbg_sel = 5'(i);
            #0.4;
            check(req, dbg_data, (i < 17) ? model[i] : 32'h0);
        end
        dbg_sel = '0;
    endtask

    // One strobed cycle, then check the results due one clock later.
    task automatic issue(string req, logic [31:0] w, logic [31:0] gin,
                         logic exp_we, logic [4:0] exp_num, logic [31:0] exp_wd);
        @(negedge clk);
        insn_valid = 1'b1; insn_word = w; gpr_rdata = gin;
        @(negedge clk);
        insn_valid = 1'b0; insn_word = 32'h0; gpr_rdata = 32'h0;
        check({req, " gpr_we"}, 32'(gpr_we), 32'(exp_we));
        if (exp_we) begin
            check({req, " gpr_wnum"}, 32'(gpr_wnum), 32'(exp_num));
            check({req, " gpr_wdata"}, gpr_wdata, exp_wd);
        end
        sweep(req);
        @(negedge clk);
        check({req, " gpr_we drop"}, 32'(gpr_we), 32'h0);
    endtask

    function automatic logic [31:0] arith_w(bit acc, logic [1:0] sel, int xd, int xc, int xb, int xa);
        return {6'b011100, sel, 2'b00, 4'(xd), 4'(xc), 4'(xb), 4'(xa), acc ? 6'b011001 : 6'b011000};
    endfunction

    function automatic logic [31:0] move_w(bit to_media, int gnum, int xm);
        return {6'b011100, 5'b0, 5'(gnum), 5'b0, 5'(xm), to_media ? 6'b101111 : 6'b101110};
    endfunction

    task automatic g2m(string req, int xm, logic [31:0] v);
        if (xm >= 1 && xm <= 16) model[xm] = v;
        issue(req, move_w(1, 0, xm), v, 1'b0, 5'd0, 32'h0);
    endtask

    task automatic m2g(string req, int xm, int gnum);
        issue(req, move_w(0, gnum, xm), 32'hdead_beef, 1'b1, 5'(gnum),
              (xm <= 16) ? model[xm] : 32'h0);
    endtask

    // Reference: read all sources first, write XA then XD (XD wins).
    task automatic arith(string req, bit acc, logic [1:0] sel, int xd, int xc, int xb, int xa);
        logic [31:0] b, c, ra, rd;
        b  = model[xb]; c = model[xc];
        ra = (sel[1] ? b - c : b + c) + (acc ? model[xa] : 32'h0);
        rd = (sel[0] ? b - c : b + c) + (acc ? model[xd] : 32'h0);
        if (xa != 0) model[xa] = ra;
        if (xd != 0) model[xd] = rd;
        issue(req, arith_w(acc, sel, xd, xc, xb, xa), 32'h0, 1'b0, 5'd0, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 17; i++) model[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R10: bank and write port clear after reset
        check("R10 gpr_we", 32'(gpr_we), 32'h0);
        check("R10 gpr_wdata", gpr_wdata, 32'h0);
        sweep("R10");
        rst_n = 1'b1;
        @(negedge clk);

        // R7: inbound moves, including register 16 and out-of-range 20
        g2m("R7", 1, 32'h0000_0005);
        g2m("R7", 2, 32'h0000_0003);
        g2m("R7", 3, 32'hFFFF_FFFF);
        g2m("R7", 4, 32'h8000_0000);
        g2m("R7", 16, 32'hCAFE_0016);
        g2m("R7 out of range", 20, 32'h1234_5678);
        // R5: write to register 0 discarded
        g2m("R5 write xr0", 0, 32'h5555_AAAA);

        // R2: all four selectors
        arith("R2 sel00", 0, 2'b00, 6, 2, 1, 5);
        arith("R2 sel01", 0, 2'b01, 8, 2, 1, 7);
        arith("R2 sel10", 0, 2'b10, 10, 2, 1, 9);
        arith("R2 sel11", 0, 2'b11, 12, 1, 2, 11);
        // R5: register 0 as a source gives negation, as a destination drops
        arith("R5 negate", 0, 2'b11, 13, 1, 0, 0);
        // R4: wrap in both directions
        arith("R4 wrap", 0, 2'b01, 15, 3, 4, 14);
        arith("R4 wrap add", 0, 2'b00, 14, 3, 3, 15);
        // R3: accumulate, all selectors
        arith("R3 sel00", 1, 2'b00, 6, 2, 1, 5);
        arith("R3 sel01", 1, 2'b01, 8, 1, 2, 7);
        arith("R3 sel10", 1, 2'b10, 10, 3, 1, 9);
        arith("R3 sel11", 1, 2'b11, 12, 2, 4, 11);
        // R6: XA equals XD, and destinations used as sources
        arith("R6 same dest", 0, 2'b01, 5, 2, 1, 5);
        arith("R6 acc same dest", 1, 2'b10, 7, 7, 2, 7);
        arith("R6 read before write", 0, 2'b00, 2, 2, 1, 1);

        // R8: outbound moves
        m2g("R8", 16, 9);
        m2g("R8", 5, 31);
        m2g("R8 xr0", 0, 1);
        m2g("R8 out of range", 25, 4);

        // R1: foreign words are no-ops
        issue("R1 other major", {6'b000000, arith_w(0, 2'b00, 6, 2, 1, 5) & 32'h03FF_FFFF},
              32'h0, 1'b0, 5'd0, 32'h0);
        issue("R1 other minor", arith_w(0, 2'b00, 6, 2, 1, 5) ^ 32'h0000_0004,
              32'h0, 1'b0, 5'd0, 32'h0);
        // R11: nonzero pad bits
        issue("R11 pad", arith_w(0, 2'b00, 6, 2, 1, 5) | 32'h0040_0000,
              32'h0, 1'b0, 5'd0, 32'h0);
        issue("R11 pad acc", arith_w(1, 2'b11, 6, 2, 1, 5) | 32'h0080_0000,
              32'h0, 1'b0, 5'd0, 32'h0);

        // R9: a valid-low cycle with an owned word changes nothing
        @(negedge clk);
        insn_word = arith_w(0, 2'b00, 6, 2, 1, 5);
        gpr_rdata = 32'hFFFF_0000;
        @(negedge clk);
        insn_word = 32'h0;
        sweep("R9 idle");
        // R12: debug select beyond the bank already covered by sweep

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule